// File: doc/BRIEF.md
# Configurable External Interrupt Unit

This block sits between 32 asynchronous interrupt pins and a parent interrupt controller that only accepts active-high level requests. Each pin is synchronized, then converted into a request according to its own configuration: level sensing or edge detection, with either polarity. Edge requests, and requests raised by software, are held in a per-line latch until software clears them by writing ones. The resulting request is gated by a per-line mask before it drives the matching output line.

Software reaches the configuration and status through a small word-addressed register port. Writes take effect on the next clock edge. Reads are combinational on the address. Two status views exist: the raw request view ignores the mask, and the pending view shows only requests that are not masked.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset every mask bit reads 1, the polarity and edge-select registers read 0, no request is latched, and every output is 0.
- R2: An output bit is 1 exactly when that line's raw request is 1 and its mask bit is 0. A mask bit of 1 blocks the line.
- R3: With edge-select 0 (level sensing), the raw request follows the synchronized input. When polarity is 1 it is active while the pin is high. When polarity is 0 it is active while the pin is low. It appears two clock edges after the pin changes and drops the same way.
- R4: With edge-select 1, a rising edge (polarity 1) or a falling edge (polarity 0) sets the line's latch on the third clock edge after the pin changes. An edge in the other direction sets nothing. The latch holds after the pin returns to its inactive level.
- R5: Writing to the clear register (byte offset 0x10) clears the latch of every line whose data bit is 1. Lines whose data bit is 0 are not affected. A level-sensed line whose input is still active keeps its raw request set.
- R6: Writing to the software-request register (byte offset 0x1C) sets the latch of every line whose data bit is 1, in either mode. Lines whose data bit is 0 are not affected.
- R7: When a detected edge and a clear of the same line commit on the same clock edge, the latch ends up set.
- R8: Reading byte offset 0x0C returns the raw requests. Reading byte offset 0x08 returns the raw requests AND NOT the mask.
- R9: A request latched while its line is masked stays pending. It reaches the output as soon as the mask bit is written to 0.
- R10: The mask (0x00), polarity (0x14) and edge-select (0x18) registers read back what was written. Reads of offsets 0x04, 0x10 and 0x1C return 0, and writes to 0x04 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NLINES | Asynchronous interrupt pins, one per line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register; bits 1:0 are ignored |
| reg_wdata | input | NLINES | Write data, one bit per line |
| reg_rdata | output | NLINES | Read data for reg_addr, combinational |
| irq_out | output | NLINES | Active-high level requests to the parent controller |

## Verification
Two functions can act on the same latch in one cycle: edge detection setting it and a software clear wiping it. The bench produces this collision on purpose. It raises a pin in edge mode and times the clear write so that it commits on the third clock edge, which is exactly when the edge is latched. Set-wins is then judged by reading the raw status afterwards. A control case moves the clear one cycle later and must see the bit cleared.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

    localparam int EIU_AW = 5;

    // Word index taken from address bits 4:2
    typedef enum logic [2:0] {
        SEL_MASK   = 3'd0,
        SEL_SOURCE = 3'd1,
        SEL_PEND   = 3'd2,
        SEL_RAW    = 3'd3,
        SEL_CLEAR  = 3'd4,
        SEL_POL    = 3'd5,
        SEL_EDGE   = 3'd6,
        SEL_SWREQ  = 3'd7
    } eiu_sel_e;

endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl      = st_q.stable;
    assign lvl_prev = st_q.prev;
endmodule

// File: rtl/eiu_line.sv
module eiu_line (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic lvl_prev,
    input  logic pol,
    input  logic edge_mode,
    input  logic clr,
    input  logic sw_set,
    output logic raw
);
    typedef struct packed {
        logic pend;
    } line_t;

    line_t st_d, st_q;
    logic  rise, fall, hit, active;

    always_comb begin
        rise   = lvl & ~lvl_prev;
        fall   = ~lvl & lvl_prev;
        hit    = edge_mode & (pol ? rise : fall);
        active = ~(lvl ^ pol);
        st_d   = st_q;
        // set sources override a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr) | hit | sw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw = st_q.pend | (~edge_mode & active);
endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
    import eiu_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [EIU_AW-1:0] addr,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      raw,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      mask,
    output logic [N-1:0]      pol,
    output logic [N-1:0]      edge_sel,
    output logic [N-1:0]      clr,
    output logic [N-1:0]      swset
);
    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] pol;
        logic [N-1:0] edg;
    } cfg_t;

    cfg_t     st_d, st_q;
    eiu_sel_e sel;

    always_comb begin
        sel   = eiu_sel_e'(addr[4:2]);
        st_d  = st_q;
        clr   = '0;
        swset = '0;
        if (we) begin
            case (sel)
                SEL_MASK:  st_d.mask = wdata;
                SEL_POL:   st_d.pol  = wdata;
                SEL_EDGE:  st_d.edg  = wdata;
                SEL_CLEAR: clr       = wdata;
                SEL_SWREQ: swset     = wdata;
                default:   ;
            endcase
        end
        case (sel)
            SEL_MASK: rdata = st_q.mask;
            SEL_PEND: rdata = raw & ~st_q.mask;
            SEL_RAW:  rdata = raw;
            SEL_POL:  rdata = st_q.pol;
            SEL_EDGE: rdata = st_q.edg;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.pol  <= '0;
            st_q.edg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask     = st_q.mask;
    assign pol      = st_q.pol;
    assign edge_sel = st_q.edg;
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import eiu_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              reg_we,
    input  logic [EIU_AW-1:0] reg_addr,
    input  logic [NLINES-1:0] reg_wdata,
    output logic [NLINES-1:0] reg_rdata,
    output logic [NLINES-1:0] irq_out
);
    logic [NLINES-1:0] sync_lvl, sync_prev;
    logic [NLINES-1:0] raw, mask, pol, edge_sel, clr, swset;

    eiu_sync #(.W(NLINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .lvl      (sync_lvl),
        .lvl_prev (sync_prev)
    );

    eiu_regs #(.N(NLINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .raw      (raw),
        .rdata    (reg_rdata),
        .mask     (mask),
        .pol      (pol),
        .edge_sel (edge_sel),
        .clr      (clr),
        .swset    (swset)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        eiu_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .lvl       (sync_lvl[g]),
            .lvl_prev  (sync_prev[g]),
            .pol       (pol[g]),
            .edge_mode (edge_sel[g]),
            .clr       (clr[g]),
            .sw_set    (swset[g]),
            .raw       (raw[g])
        );
    end

    assign irq_out = raw & ~mask;
endmodule

// File: rtl/eiu_chk.sv
module eiu_chk
    import eiu_pkg::*;
#(
    parameter int N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [EIU_AW-1:0] reg_addr,
    input logic [N-1:0]      reg_wdata,
    input logic [N-1:0]      reg_rdata,
    input logic [N-1:0]      irq_out,
    input logic [N-1:0]      raw,
    input logic [N-1:0]      mask,
    input logic [N-1:0]      pol,
    input logic [N-1:0]      edge_sel,
    input logic [N-1:0]      sync_lvl,
    input logic [N-1:0]      clr
);
    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & mask) == '0); // R2

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((~edge_sel & ~(sync_lvl ^ pol)) & ~raw) == '0); // R3

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(raw) & $past(edge_sel)) & ~$past(clr)) & ~raw) == '0)); // R4

    AST_SWREQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[4:2] == SEL_SWREQ) |=> (($past(reg_wdata) & ~raw) == '0)); // R6

    AST_PEND_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[4:2] == SEL_PEND) |-> (reg_rdata == (raw & ~mask))); // R8
endmodule

bind ext_irq_unit eiu_chk #(.N(NLINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .raw       (raw),
    .mask      (mask),
    .pol       (pol),
    .edge_sel  (edge_sel),
    .sync_lvl  (sync_lvl),
    .clr       (clr)
);

// File: tb/ext_irq_unit_test.sv
module ext_irq_unit_test;
    localparam int CLK_P = 10;
    localparam int N     = 32;

    localparam logic [4:0] A_MASK = 5'h00, A_SRC = 5'h04, A_PEND = 5'h08, A_RAW = 5'h0C,
                           A_CLR  = 5'h10, A_POL = 5'h14, A_EDGE = 5'h18, A_SW  = 5'h1C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '1;
    logic         reg_we = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata, irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    ext_irq_unit #(.NLINES(N)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // all tasks are entered and left at a falling clock edge
    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [N-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N-1:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(3);

        // R1 reset state
        rd(A_MASK, v); chk("R1 mask", v, '1);
        rd(A_POL,  v); chk("R1 pol", v, '0);
        rd(A_EDGE, v); chk("R1 edge", v, '0);
        rd(A_RAW,  v); chk("R1 raw", v, '0);
        chk("R1 out", irq_out, '0);

        // R10 readback and read-as-zero offsets
        wr(A_POL, 32'h1234_5678);  rd(A_POL, v);  chk("R10 pol", v, 32'h1234_5678);
        wr(A_EDGE, 32'h0F0F_0000); rd(A_EDGE, v); chk("R10 edge", v, 32'h0F0F_0000);
        wr(A_MASK, 32'hDEAD_BEEF); rd(A_MASK, v); chk("R10 mask", v, 32'hDEAD_BEEF);
        wr(A_SRC, '1);             rd(A_SRC, v);  chk("R10 source", v, '0);
        rd(A_CLR, v); chk("R10 clear", v, '0);
        rd(A_SW, v);  chk("R10 swreq", v, '0);
        wr(A_POL, '0); wr(A_EDGE, '0); wr(A_MASK, '1);
        idle(4); wr(A_CLR, '1);
        rd(A_RAW, v); chk("R10 raw after source write", v, '0);

        // R5 / R6 zero bits have no effect
        wr(A_SW, 32'hA5A5_A5A5);  rd(A_RAW, v); chk("R6 swreq set", v, 32'hA5A5_A5A5);
        wr(A_CLR, 32'h0000_FFFF); rd(A_RAW, v); chk("R5 partial clear", v, 32'hA5A5_0000);
        wr(A_SW, '0);             rd(A_RAW, v); chk("R6 zero write", v, 32'hA5A5_0000);
        wr(A_CLR, '1);            rd(A_RAW, v); chk("R5 full clear", v, '0);

        // R5 level line stays active through a clear
        irq_in[7] = 1'b0; idle(4);
        wr(A_CLR, 32'h80); rd(A_RAW, v); chk("R5 level survives clear", v, 32'h80);
        irq_in[7] = 1'b1; idle(4);
        rd(A_RAW, v); chk("R3 level drops", v, '0);

        // R3 level latency: visible two edges after the pin changes
        irq_in[9] = 1'b0; idle(1);
        rd(A_RAW, v); chk("R3 latency one edge", v, '0);
        idle(1);
        rd(A_RAW, v); chk("R3 latency two edges", v, 32'h200);
        irq_in[9] = 1'b1; idle(4);

        // R4 edge latency and R7 collision with clear
        irq_in = '0; idle(4);
        wr(A_POL, '1); wr(A_EDGE, '1); idle(2); wr(A_CLR, '1);
        irq_in[3] = 1'b1; idle(2);
        rd(A_RAW, v); chk("R4 not yet latched", v, '0);
        idle(1);
        rd(A_RAW, v); chk("R4 latched third edge", v, 32'h8);
        irq_in[3] = 1'b0; idle(4); wr(A_CLR, '1);

        irq_in[3] = 1'b1; idle(2);
        wr(A_CLR, 32'h8);
        rd(A_RAW, v); chk("R7 set wins over clear", v, 32'h8);
        irq_in[3] = 1'b0; idle(4); wr(A_CLR, '1);

        irq_in[3] = 1'b1; idle(3);
        wr(A_CLR, 32'h8);
        rd(A_RAW, v); chk("R7 control late clear", v, '0);
        irq_in[3] = 1'b0; idle(4); wr(A_CLR, '1);

        // sweep every line in every mode
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < N; i++) begin
                logic         p, e;
                logic [N-1:0] bitv;
                p = m[0]; e = m[1];
                bitv = N'(1) << i;
                irq_in = {N{~p}}; idle(4);
                wr(A_POL, {N{p}}); wr(A_EDGE, {N{e}}); idle(4);
                wr(A_CLR, '1);
                rd(A_RAW, v); chk("R1 idle raw", v, '0);
                wr(A_MASK, ~bitv);
                irq_in[i] = p; idle(4);
                rd(A_RAW, v); chk(e ? "R4 edge seen" : "R3 level seen", v, bitv);
                chk("R2 output open", irq_out, bitv);
                irq_in[i] = ~p; idle(4);
                rd(A_RAW, v); chk(e ? "R4 edge held" : "R3 level released", v, e ? bitv : '0);
                wr(A_CLR, bitv);
                rd(A_RAW, v); chk("R5 cleared", v, '0);
                wr(A_MASK, '1);
                irq_in[i] = p; idle(4);
                irq_in[i] = ~p; idle(4);
                rd(A_RAW, v); chk("R9 raw while masked", v, e ? bitv : '0);
                chk("R2 output blocked", irq_out, '0);
                rd(A_PEND, v); chk("R8 pending masked", v, '0);
                wr(A_MASK, ~bitv);
                chk("R9 unmask delivers", irq_out, e ? bitv : '0);
                rd(A_PEND, v); chk("R8 pending view", v, e ? bitv : '0);
                wr(A_CLR, '1);
                wr(A_SW, bitv);
                rd(A_RAW, v); chk("R6 software set", v, bitv);
                wr(A_CLR, bitv);
                rd(A_RAW, v); chk("R5 software cleared", v, '0);
            end
        end

        finish_run();
    end
endmodule